// File: doc/BRIEF.md
# Interrupt Status and Mask Unit

This block keeps the interrupt state of a network controller in two 32-bit registers: a status register and a mask register. Both sit behind a plain register-bus port, written through a one-cycle write strobe and read back through a combinational data path. One level-sensitive interrupt line leaves the block.

Completion pulses from the receive engine and the transmit engine load a fixed code into the status register. They replace whatever was there and do not merge into it. Software clears status bits by writing ones to them. Software can also wipe the whole status register by writing the transmit/receive control word with the clear bit set. The line is not a per-bit masked OR. It is high whenever the mask register holds any nonzero value and the status register holds any nonzero value. Because the line is formed directly from the two registers, it follows every change to either register in the same cycle that change becomes visible.

Top module: `irq_status_unit`

## Requirements
- R1: Synchronous active-high reset clears the status and mask registers to zero, so the interrupt line is low after reset.
- R2: A write to offset 0x000 clears each status bit whose written bit is 1 and leaves every other status bit unchanged.
- R3: A write to offset 0x004 stores the full 32-bit value in the mask register. Reading offset 0x000 or 0x004 returns the stored value and has no side effect.
- R4: The interrupt line is high exactly when the mask register is nonzero and the status register is nonzero, even if no status bit lines up with a mask bit. It follows a register change in the cycle that change becomes visible.
- R5: A receive-completion pulse loads the status register with exactly 0x00000002, discarding its earlier contents.
- R6: A transmit-completion pulse loads the status register with exactly 0x00000010, discarding its earlier contents.
- R7: A write to offset 0x144 with bit 1 set and bit 2 clear forces the status register to zero. A write to 0x144 with bit 2 set, or with bit 1 clear, leaves the status register unchanged.
- R8: When an event pulse and a software status write or clear land in the same cycle, the event load wins. When both event pulses coincide, the receive code is loaded. Mask writes are not affected by events.
- R9: Writes to any other offset change neither register. Reads of any other offset return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 12 | Byte offset for write and read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| rx_done | input | 1 | Receive-completion pulse |
| tx_done | input | 1 | Transmit-completion pulse |
| irq_o | output | 1 | Level interrupt line |

## Verification
Two things can hit the status register in the same cycle: an engine's completion load and a software write, either a write-one-to-clear or a control-word clear. The bench forces that overlap on purpose. It issues a receive pulse together with a clear that would erase the loaded code, a transmit pulse together with a control-word clear, and both pulses together. It then reads the status back and expects the event code. Random traffic also raises event pulses while bus writes are in progress, and every result is compared with the bench's own register model.

// File: rtl/irq_unit_pkg.sv
package irq_unit_pkg;

    // Byte offsets decoded by the unit
    localparam int OFS_STATUS = 'h000;
    localparam int OFS_MASK   = 'h004;
    localparam int OFS_CTRL   = 'h144;

    // Control word bit positions (bit 2 takes precedence over bit 1)
    localparam int CTRL_CLR_BIT  = 1;
    localparam int CTRL_IDLE_BIT = 2;

    // Codes loaded by completion events
    localparam int RX_CODE = 'h02;
    localparam int TX_CODE = 'h10;

    typedef enum logic [2:0] {
        SRC_HOLD,
        SRC_RX,
        SRC_TX,
        SRC_FLUSH,
        SRC_W1C
    } st_src_e;

    // Priority: receive event, transmit event, control clear, status write
    function automatic st_src_e pick_src(input logic rx, input logic tx,
                                         input logic flush, input logic w1c);
        if (rx)         return SRC_RX;
        else if (tx)    return SRC_TX;
        else if (flush) return SRC_FLUSH;
        else if (w1c)   return SRC_W1C;
        else            return SRC_HOLD;
    endfunction

endpackage

// File: rtl/irq_status_reg.sv
module irq_status_reg
    import irq_unit_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_ev,
    input  logic              tx_ev,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] status_q
);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
    localparam logic [DATA_W-1:0] V_RX     = DATA_W'(RX_CODE);
    localparam logic [DATA_W-1:0] V_TX     = DATA_W'(TX_CODE);

    logic              hit_st;
    logic              hit_ctrl;
    logic              flush;
    st_src_e           src;
    logic [DATA_W-1:0] status_d;

    assign hit_st   = wr_en && (wr_addr == A_STATUS);
    assign hit_ctrl = wr_en && (wr_addr == A_CTRL);
    assign flush    = hit_ctrl && wr_data[CTRL_CLR_BIT] && !wr_data[CTRL_IDLE_BIT];
    assign src      = pick_src(rx_ev, tx_ev, flush, hit_st);

    always_comb begin
        case (src)
            SRC_RX:    status_d = V_RX;
            SRC_TX:    status_d = V_TX;
            SRC_FLUSH: status_d = '0;
            SRC_W1C:   status_d = status_q & ~wr_data;
            default:   status_d = status_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) status_q <= '0;
        else     status_q <= status_d;
    end

    AST_RX_LOAD: assert property (@(posedge clk) disable iff (rst)
        rx_ev |=> status_q == V_RX); // R5
    AST_TX_LOAD: assert property (@(posedge clk) disable iff (rst)
        (tx_ev && !rx_ev) |=> status_q == V_TX); // R6
    AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (hit_st && !rx_ev && !tx_ev) |=> status_q == ($past(status_q) & ~$past(wr_data))); // R2
    AST_CTRL_FLUSH: assert property (@(posedge clk) disable iff (rst)
        (hit_ctrl && wr_data[CTRL_CLR_BIT] && !wr_data[CTRL_IDLE_BIT] && !rx_ev && !tx_ev)
        |=> status_q == '0); // R7
    AST_CTRL_IDLE_KEEP: assert property (@(posedge clk) disable iff (rst)
        (hit_ctrl && wr_data[CTRL_IDLE_BIT] && !rx_ev && !tx_ev) |=> $stable(status_q)); // R7

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
    import irq_unit_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] mask_q
);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);

    logic hit;
    assign hit = wr_en && (wr_addr == A_MASK);

    always_ff @(posedge clk) begin
        if (rst)      mask_q <= '0;
        else if (hit) mask_q <= wr_data;
    end

    AST_MASK_STORE: assert property (@(posedge clk) disable iff (rst)
        hit |=> mask_q == $past(wr_data)); // R3
    AST_MASK_KEEP: assert property (@(posedge clk) disable iff (rst)
        !hit |=> $stable(mask_q)); // R9

endmodule

// File: rtl/irq_line_drv.sv
module irq_line_drv #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] mask_q,
    input  logic [DATA_W-1:0] status_q,
    output logic              line_o
);
    logic any_mask;
    logic any_status;

    assign any_mask   = |mask_q;
    assign any_status = |status_q;
    assign line_o     = any_mask && any_status;

endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
    import irq_unit_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rx_done,
    input  logic              tx_done,
    output logic              irq_o
);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(OFS_MASK);

    logic [DATA_W-1:0] status_q;
    logic [DATA_W-1:0] mask_q;

    irq_status_reg #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_status (
        .clk      (clk),
        .rst      (rst),
        .rx_ev    (rx_done),
        .tx_ev    (tx_done),
        .wr_en    (bus_wr),
        .wr_addr  (bus_addr),
        .wr_data  (bus_wdata),
        .status_q (status_q)
    );

    irq_mask_reg #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mask (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (bus_wr),
        .wr_addr (bus_addr),
        .wr_data (bus_wdata),
        .mask_q  (mask_q)
    );

    irq_line_drv #(.DATA_W(DATA_W)) u_line (
        .mask_q   (mask_q),
        .status_q (status_q),
        .line_o   (irq_o)
    );

    always_comb begin
        if (bus_addr == A_STATUS)    bus_rdata = status_q;
        else if (bus_addr == A_MASK) bus_rdata = mask_q;
        else                         bus_rdata = '0;
    end

    AST_RX_RAISES_LINE: assert property (@(posedge clk) disable iff (rst)
        (rx_done && (mask_q != '0) && !(bus_wr && bus_addr == A_MASK)) |=> irq_o); // R4
    AST_NO_MASK_NO_LINE: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |-> !irq_o); // R4

endmodule

// File: tb/irq_status_unit_tb.sv
module irq_status_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_done = 1'b0;
    logic        tx_done = 1'b0;
    logic        irq_o;

    int unsigned n_vec = 0;
    int unsigned n_bad = 0;
    logic [31:0] m_st = '0;
    logic [31:0] m_mask = '0;
    bit          finished = 1'b0;

    always #4 clk = ~clk;

    irq_status_unit u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_done(rx_done), .tx_done(tx_done), .irq_o(irq_o)
    );

    function automatic logic [31:0] next_status(input logic [31:0] st, input logic w,
            input logic [11:0] a, input logic [31:0] d, input logic r, input logic t);
        if (r) return 32'h2;
        if (t) return 32'h10;
        if (w && a == 12'h144 && d[1] && !d[2]) return 32'h0;
        if (w && a == 12'h000) return st & ~d;
        return st;
    endfunction

    function automatic logic exp_line(input logic [31:0] mk, input logic [31:0] st);
        return (mk != 0) && (st != 0);
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic apply(input logic w, input logic [11:0] a, input logic [31:0] d,
                         input logic r, input logic t, input string tag);
        @(negedge clk);
        bus_wr = w; bus_addr = a; bus_wdata = d; rx_done = r; tx_done = t;
        @(posedge clk);
        m_st = next_status(m_st, w, a, d, r, t);
        if (w && a == 12'h004) m_mask = d;
        #1;
        bus_wr = 1'b0; rx_done = 1'b0; tx_done = 1'b0; bus_addr = 12'h000;
        #1 check(bus_rdata, m_st, tag);
        bus_addr = 12'h004;
        #1 check(bus_rdata, m_mask, "R3");
        check({31'b0, irq_o}, {31'b0, exp_line(m_mask, m_st)}, "R4");
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        // R1: reset state
        bus_addr = 12'h000;
        #1 check(bus_rdata, 32'h0, "R1");
        bus_addr = 12'h004;
        #1 check(bus_rdata, 32'h0, "R1");
        check({31'b0, irq_o}, 32'h0, "R1");

        // R6 + R4: line rises with non-overlapping mask and status bits
        apply(1, 12'h004, 32'h1, 0, 0, "R3");
        apply(0, 12'h000, 32'h0, 0, 1, "R6");
        // R2: write one to clear
        apply(1, 12'h000, 32'h10, 0, 0, "R2");
        // R5 overwrites earlier contents
        apply(0, 12'h000, 32'h0, 0, 1, "R6");
        apply(0, 12'h000, 32'h0, 1, 0, "R5");
        // R8: receive event beats clearing write
        apply(1, 12'h000, 32'hFFFF_FFFF, 1, 0, "R8");
        // R7: idle bit blocks clear, then clear works
        apply(1, 12'h144, 32'h6, 0, 0, "R7");
        apply(1, 12'h144, 32'h1, 0, 0, "R7");
        apply(1, 12'h144, 32'h2, 0, 0, "R7");
        // R8: both events, receive wins; transmit beats control clear
        apply(0, 12'h000, 32'h0, 1, 1, "R8");
        apply(1, 12'h144, 32'h2, 0, 1, "R8");
        // R8: mask write still lands with an event
        apply(1, 12'h004, 32'h8000_0000, 1, 0, "R8");
        // R4: zero mask drops the line
        apply(1, 12'h004, 32'h0, 0, 0, "R4");
        // R9: other offset write ignored, read returns zero
        apply(1, 12'h008, 32'hFFFF_FFFF, 0, 0, "R9");
        @(negedge clk) bus_addr = 12'h008;
        #1 check(bus_rdata, 32'h0, "R9");
        bus_addr = 12'h000;
        #1 check(bus_rdata, m_st, "R9");

        for (int i = 0; i < 600; i++) begin
            logic        w, r, t;
            logic [11:0] a;
            logic [31:0] d;
            string       tag;
            int unsigned op;
            op = $urandom % 8;
            r  = ($urandom % 6) == 0;
            t  = ($urandom % 6) == 0;
            w  = 1'b1;
            d  = $urandom;
            case (op)
                0, 1: begin a = 12'h000; tag = "R2"; end
                2:    begin a = 12'h004; if ($urandom % 3 == 0) d = 0; tag = "R3"; end
                3:    begin
                          a = 12'h144; tag = "R7";
                          case ($urandom % 4)
                              0: d = 32'h2;
                              1: d = 32'h6;
                              2: d = 32'h1;
                              default: ;
                          endcase
                      end
                4:    begin a = 12'h008; tag = "R9"; end
                default: begin a = 12'h000; w = 1'b0; tag = "R4"; end
            endcase
            if ((r || t) && w && (a == 12'h000 || a == 12'h144)) tag = "R8";
            else if (r) tag = "R5";
            else if (t) tag = "R6";
            apply(w, a, d, r, t, tag);
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule